// File: doc/BRIEF.md
# Half-Open Session Admission Monitor

This block guards a stateful connection tracker against floods of unfinished TCP handshakes. A session tracker sends it one-cycle event pulses: a new half-open session was created, a half-open session completed its handshake, or a half-open session was removed by timeout. Each pulse carries the destination host address. From these events the block keeps three counts: every half-open session in the system, the new unestablished sessions seen in the current rate window, and the half-open sessions per destination hash bucket.

When the tracker asks about a new connection attempt, the block answers in the same cycle with admit or deny. An attempt is admitted only when all three counts lie below their programmed limits. Each limit that stops an attempt raises its own sticky alarm flag. Limits are written, and alarms are cleared, through a small register write port. The rate window is marked by an external tick, usually one per second.

Top module: `halfopen_admit_mon`

## Requirements
- R1: After reset all counts and alarms are zero and the three limits hold their parameter defaults (global DEF_G, rate DEF_R, host DEF_H).
- R2: The global count rises by one on each open event and falls by one on each established event and on each drop event; events in the same cycle add up to a net change.
- R3: The rate count rises by one on each open event and clears on win_tick; an open event in the same cycle as win_tick leaves the count at one, so it belongs to the new window.
- R4: Each event changes only the bucket picked by its own address; the bucket index is the XOR of all IDX_W-bit slices of the address (for 16 buckets, the XOR of its eight 4-bit nibbles).
- R5: With try_valid high, admit is high in the same cycle exactly when global count < global limit, rate count < rate limit and the try_addr bucket count < host limit; otherwise deny is high. With try_valid low both are low.
- R6: alarm bit 0 (global), bit 1 (rate) and bit 2 (host) are set from the cycle after a try_valid cycle in which that count was at or above its limit, and they stay set.
- R7: A write with cfg_sel = 3 clears each alarm bit whose cfg_wdata bit (bits 2:0) is one; when a bit is set and cleared in the same cycle, the set wins.
- R8: A write with cfg_sel = 0, 1 or 2 loads the global, rate or host limit from cfg_wdata, used from the next cycle; a limit of zero denies every attempt.
- R9: A count at zero stays at zero when a decrement arrives for it.
- R10: A count at its maximum value (all ones) stays there when an increment arrives for it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| open_evt | input | 1 | A half-open session was created |
| open_addr | input | ADDR_W | Destination address of the created session |
| estab_evt | input | 1 | A half-open session completed its handshake |
| estab_addr | input | ADDR_W | Destination address of the established session |
| drop_evt | input | 1 | A half-open session was removed |
| drop_addr | input | ADDR_W | Destination address of the removed session |
| win_tick | input | 1 | Start of a new rate window |
| try_valid | input | 1 | A new connection attempt asks for admission |
| try_addr | input | ADDR_W | Destination address of the attempt |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 2 | 0 global limit, 1 rate limit, 2 host limit, 3 alarm clear |
| cfg_wdata | input | CNT_W | Write data (limit value or clear mask) |
| admit | output | 1 | Attempt admitted |
| deny | output | 1 | Attempt denied |
| alarm | output | 3 | Sticky alarm flags: global, rate, host |

## Verification
Two functions meet in one cycle in the alarm path: a denied attempt that sets an alarm bit and a register write that clears it. The bench provokes this in a directed step by sending a denied attempt and a clear-all write together, expecting the bit to stay set, then a bare clear expecting zero; the random phase repeats the collision often with small limits. A second collision, win_tick together with an open event, is judged by whether the next attempt sees a rate count of one against a limit of two.

// File: rtl/hoam_pkg.sv
package hoam_pkg;

    typedef enum logic [1:0] {
        SEL_GLB  = 2'd0,
        SEL_RATE = 2'd1,
        SEL_HOST = 2'd2,
        SEL_CLR  = 2'd3
    } cfg_sel_e;

    localparam int ALM_GLB  = 0;
    localparam int ALM_RATE = 1;
    localparam int ALM_HOST = 2;
    localparam int N_ALM    = 3;

endpackage

// File: rtl/hoam_hash.sv
module hoam_hash #(
    parameter int ADDR_W = 32,
    parameter int IDX_W  = 4
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [IDX_W-1:0]  idx
);
    localparam int NSL   = (ADDR_W + IDX_W - 1) / IDX_W;
    localparam int PAD_W = NSL * IDX_W;

    logic [PAD_W-1:0] padded;
    assign padded = PAD_W'(addr);

    // fold the address into one bucket index by XOR of equal slices
    always_comb begin
        idx = '0;
        for (int i = 0; i < NSL; i++) begin
            idx = idx ^ padded[i*IDX_W +: IDX_W];
        end
    end
endmodule

// File: rtl/hoam_satcnt.sv
module hoam_satcnt #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         inc,
    input  logic [1:0]   dec,
    output logic [W-1:0] cnt
);
    localparam int XW = W + 2;
    localparam logic [XW-1:0] MAXV = {2'b00, {W{1'b1}}};

    logic [W-1:0]  cnt_d, cnt_q;
    logic [XW-1:0] base, up, dn;

    always_comb begin
        base = clr ? '0 : {2'b00, cnt_q};
        up   = base + {{(XW-1){1'b0}}, inc};
        dn   = {{(XW-2){1'b0}}, dec};
        if (up < dn) begin
            cnt_d = '0;
        end else if ((up - dn) > MAXV) begin
            cnt_d = MAXV[W-1:0];
        end else begin
            cnt_d = W'(up - dn);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign cnt = cnt_q;
endmodule

// File: rtl/halfopen_admit_mon.sv
module halfopen_admit_mon
    import hoam_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 16,
    parameter int NBKT   = 16,
    parameter int DEF_G  = 2048,
    parameter int DEF_R  = 500,
    parameter int DEF_H  = 100
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              open_evt,
    input  logic [ADDR_W-1:0] open_addr,
    input  logic              estab_evt,
    input  logic [ADDR_W-1:0] estab_addr,
    input  logic              drop_evt,
    input  logic [ADDR_W-1:0] drop_addr,
    input  logic              win_tick,
    input  logic              try_valid,
    input  logic [ADDR_W-1:0] try_addr,
    input  logic              cfg_we,
    input  logic [1:0]        cfg_sel,
    input  logic [CNT_W-1:0]  cfg_wdata,
    output logic              admit,
    output logic              deny,
    output logic [2:0]        alarm
);
    // NBKT must be a power of two, at least 2
    localparam int IDX_W = $clog2(NBKT);

    typedef struct packed {
        logic [CNT_W-1:0] thr_g;
        logic [CNT_W-1:0] thr_r;
        logic [CNT_W-1:0] thr_h;
        logic [N_ALM-1:0] alm;
    } regs_t;

    regs_t st_d, st_q;

    logic [IDX_W-1:0] h_open, h_estab, h_drop, h_try;
    logic [CNT_W-1:0] gcnt, rcnt, hcnt;
    logic [CNT_W-1:0] bkt_cnt [NBKT];
    logic [1:0]       g_dec;
    logic             ok_g, ok_r, ok_h, all_ok;

    hoam_hash #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_hash_open  (.addr(open_addr),  .idx(h_open));
    hoam_hash #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_hash_estab (.addr(estab_addr), .idx(h_estab));
    hoam_hash #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_hash_drop  (.addr(drop_addr),  .idx(h_drop));
    hoam_hash #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_hash_try   (.addr(try_addr),   .idx(h_try));

    // global half-open count: handshake completion and removal both leave
    assign g_dec = {1'b0, estab_evt} + {1'b0, drop_evt};

    hoam_satcnt #(.W(CNT_W)) u_glb (
        .clk(clk), .rst_n(rst_n), .clr(1'b0),
        .inc(open_evt), .dec(g_dec), .cnt(gcnt)
    );

    // window rate count: the tick starts a new window, same-cycle open lands in it
    hoam_satcnt #(.W(CNT_W)) u_rate (
        .clk(clk), .rst_n(rst_n), .clr(win_tick),
        .inc(open_evt), .dec(2'b00), .cnt(rcnt)
    );

    // per-destination bucket counts
    for (genvar b = 0; b < NBKT; b++) begin : g_bkt
        logic       b_inc;
        logic [1:0] b_dec;
        assign b_inc = open_evt && (h_open == IDX_W'(b));
        assign b_dec = {1'b0, estab_evt && (h_estab == IDX_W'(b))}
                     + {1'b0, drop_evt  && (h_drop  == IDX_W'(b))};
        hoam_satcnt #(.W(CNT_W)) u_cnt (
            .clk(clk), .rst_n(rst_n), .clr(1'b0),
            .inc(b_inc), .dec(b_dec), .cnt(bkt_cnt[b])
        );
    end

    assign hcnt   = bkt_cnt[h_try];
    assign ok_g   = gcnt < st_q.thr_g;
    assign ok_r   = rcnt < st_q.thr_r;
    assign ok_h   = hcnt < st_q.thr_h;
    assign all_ok = ok_g && ok_r && ok_h;

    assign admit = try_valid && all_ok;
    assign deny  = try_valid && !all_ok;
    assign alarm = st_q.alm;

    always_comb begin
        logic [N_ALM-1:0] clr_m, set_m;
        st_d  = st_q;
        clr_m = '0;
        set_m = '0;
        if (cfg_we) begin
            case (cfg_sel_e'(cfg_sel))
                SEL_GLB:  st_d.thr_g = cfg_wdata;
                SEL_RATE: st_d.thr_r = cfg_wdata;
                SEL_HOST: st_d.thr_h = cfg_wdata;
                default:  clr_m      = cfg_wdata[N_ALM-1:0];
            endcase
        end
        if (try_valid) begin
            set_m[ALM_GLB]  = !ok_g;
            set_m[ALM_RATE] = !ok_r;
            set_m[ALM_HOST] = !ok_h;
        end
        // a new violation outranks a clear in the same cycle
        st_d.alm = (st_q.alm & ~clr_m) | set_m;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.thr_g <= CNT_W'(DEF_G);
            st_q.thr_r <= CNT_W'(DEF_R);
            st_q.thr_h <= CNT_W'(DEF_H);
            st_q.alm   <= '0;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/hoam_chk.sv
module hoam_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             open_evt,
    input logic             win_tick,
    input logic             try_valid,
    input logic             cfg_we,
    input logic [1:0]       cfg_sel,
    input logic [2:0]       clr_bits,
    input logic             admit,
    input logic             deny,
    input logic [2:0]       alarm,
    input logic [CNT_W-1:0] gcnt,
    input logic [CNT_W-1:0] rcnt,
    input logic [CNT_W-1:0] thr_g
);
    logic [2:0] clr_m;
    assign clr_m = (cfg_we && cfg_sel == 2'd3) ? clr_bits : 3'b000;

    // R5
    admit_deny_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(admit && deny));

    // R5
    idle_no_answer_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !try_valid |-> (!admit && !deny));

    // R2
    glb_no_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !open_evt |=> (gcnt <= $past(gcnt)));

    // R3
    rate_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        win_tick |=> (rcnt <= CNT_W'(1)));

    // R6
    alarm_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((($past(alarm) & ~$past(clr_m)) & ~alarm) == 3'b000));

    // R6
    alarm_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((alarm & ~$past(alarm)) != 3'b000) |-> $past(deny));

    // R8
    zero_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (thr_g == '0) |-> !admit);
endmodule

bind halfopen_admit_mon hoam_chk #(.CNT_W(CNT_W)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .open_evt  (open_evt),
    .win_tick  (win_tick),
    .try_valid (try_valid),
    .cfg_we    (cfg_we),
    .cfg_sel   (cfg_sel),
    .clr_bits  (cfg_wdata[2:0]),
    .admit     (admit),
    .deny      (deny),
    .alarm     (alarm),
    .gcnt      (gcnt),
    .rcnt      (rcnt),
    .thr_g     (st_q.thr_g)
);

// File: tb/halfopen_admit_mon_tb_top.sv
module halfopen_admit_mon_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W = 32;
    localparam int CNT_W  = 10;
    localparam int NBKT   = 16;
    localparam int MAXC   = (1 << CNT_W) - 1;
    localparam int DEF_G  = 600;
    localparam int DEF_R  = 300;
    localparam int DEF_H  = 50;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic open_evt = 0, estab_evt = 0, drop_evt = 0, win_tick = 0, try_valid = 0, cfg_we = 0;
    logic [ADDR_W-1:0] open_addr = '0, estab_addr = '0, drop_addr = '0, try_addr = '0;
    logic [1:0] cfg_sel = '0;
    logic [CNT_W-1:0] cfg_wdata = '0;
    logic admit, deny;
    logic [2:0] alarm;

    always #(CLK_PERIOD/2) clk = ~clk;

    halfopen_admit_mon #(
        .ADDR_W(ADDR_W), .CNT_W(CNT_W), .NBKT(NBKT),
        .DEF_G(DEF_G), .DEF_R(DEF_R), .DEF_H(DEF_H)
    ) dut_i (
        .clk(clk), .rst_n(rst_n),
        .open_evt(open_evt), .open_addr(open_addr),
        .estab_evt(estab_evt), .estab_addr(estab_addr),
        .drop_evt(drop_evt), .drop_addr(drop_addr),
        .win_tick(win_tick),
        .try_valid(try_valid), .try_addr(try_addr),
        .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
        .admit(admit), .deny(deny), .alarm(alarm)
    );

    int n_chk = 0;
    int n_fail = 0;
    int mg, mr;
    int mb [NBKT];
    int tg, tr, th;
    int malm;
    bit finished = 0;

    function automatic int hfn(input logic [ADDR_W-1:0] a);
        logic [3:0] x = '0;
        for (int i = 0; i < 8; i++) x = x ^ a[i*4 +: 4];
        return int'(x);
    endfunction

    function automatic int clampc(input int v);
        if (v < 0) return 0;
        if (v > MAXC) return MAXC;
        return v;
    endfunction

    task automatic chk(input bit good, input string req, input int act, input int exp);
        n_chk++;
        if (!good) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic clear_in();
        open_evt = 0; estab_evt = 0; drop_evt = 0; win_tick = 0;
        try_valid = 0; cfg_we = 0; cfg_sel = '0; cfg_wdata = '0;
    endtask

    // inputs are set right after a falling edge; outputs are checked 1 time unit later
    task automatic cyc(input string tag);
        int ht, ho, he, hd, setm, clrm;
        bit okg, okr, okh, ea, ed;
        #1;
        ht  = hfn(try_addr);
        okg = mg < tg;
        okr = mr < tr;
        okh = mb[ht] < th;
        ea  = try_valid && okg && okr && okh;
        ed  = try_valid && !(okg && okr && okh);
        chk(admit === ea, {tag, " admit"}, int'(admit), int'(ea));
        chk(deny === ed,  {tag, " deny"},  int'(deny),  int'(ed));
        chk(alarm === 3'(malm), {tag, " alarm"}, int'(alarm), malm);
        ho = hfn(open_addr); he = hfn(estab_addr); hd = hfn(drop_addr);
        mg = clampc(mg + int'(open_evt) - int'(estab_evt) - int'(drop_evt));
        mr = win_tick ? int'(open_evt) : clampc(mr + int'(open_evt));
        for (int b = 0; b < NBKT; b++)
            mb[b] = clampc(mb[b] + int'(open_evt && ho == b)
                          - int'(estab_evt && he == b) - int'(drop_evt && hd == b));
        setm = try_valid ? (int'(!okg) | (int'(!okr) << 1) | (int'(!okh) << 2)) : 0;
        clrm = 0;
        if (cfg_we) begin
            case (cfg_sel)
                2'd0: tg = int'(cfg_wdata);
                2'd1: tr = int'(cfg_wdata);
                2'd2: th = int'(cfg_wdata);
                default: clrm = int'(cfg_wdata[2:0]);
            endcase
        end
        malm = (malm & ~clrm & 7) | setm;
        @(negedge clk);
        clear_in();
    endtask

    task automatic wr(input int sel, input int val, input string tag);
        cfg_we = 1; cfg_sel = 2'(sel); cfg_wdata = CNT_W'(val);
        cyc(tag);
    endtask

    task automatic ask(input logic [ADDR_W-1:0] a, input string tag);
        try_valid = 1; try_addr = a;
        cyc(tag);
    endtask

    // addresses: A and B share bucket 3, C is bucket 5
    localparam logic [ADDR_W-1:0] ADR_A = 32'h0000_0012;
    localparam logic [ADDR_W-1:0] ADR_B = 32'h0000_0030;
    localparam logic [ADDR_W-1:0] ADR_C = 32'h0000_0005;

    initial begin
        logic [ADDR_W-1:0] pool [8];
        void'($urandom(32'h5EED_0042));
        mg = 0; mr = 0; malm = 0;
        for (int b = 0; b < NBKT; b++) mb[b] = 0;
        tg = DEF_G; tr = DEF_R; th = DEF_H;
        clear_in();
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);

        // R1: reset state, default limits admit
        ask(ADR_A, "R1 reset");
        cyc("R1 idle");

        // R2: global limit 3
        wr(0, 3, "R8 write glb");
        open_evt = 1; open_addr = ADR_A; cyc("R2 open");
        open_evt = 1; open_addr = ADR_C; cyc("R2 open");
        open_evt = 1; open_addr = 32'h0000_0100; cyc("R2 open");
        ask(32'h0000_0007, "R2 at limit");
        ask(32'h0000_0007, "R6 global alarm");
        estab_evt = 1; estab_addr = ADR_C; cyc("R2 estab");
        ask(32'h0000_0007, "R2 below limit");
        // simultaneous open + drop: net zero
        open_evt = 1; open_addr = ADR_C; drop_evt = 1; drop_addr = 32'h0000_0100; cyc("R2 net");
        ask(32'h0000_0007, "R2 net zero");
        wr(3, 7, "R7 clear all");
        ask(32'h0000_0007, "R7 cleared");

        // R9: drain then decrement at zero
        estab_evt = 1; estab_addr = ADR_A; drop_evt = 1; drop_addr = ADR_C; cyc("R9 drain");
        for (int i = 0; i < 3; i++) begin
            drop_evt = 1; drop_addr = ADR_A; estab_evt = 1; estab_addr = ADR_C; cyc("R9 under");
        end
        wr(0, 2, "R8 write glb");
        wr(2, 1, "R8 write host");
        open_evt = 1; open_addr = ADR_C; cyc("R9 open");
        ask(32'h0000_0007, "R9 floor");

        // R4: bucket sharing
        ask(ADR_C, "R4 full bucket");
        wr(0, 100, "R8 write glb");
        open_evt = 1; open_addr = ADR_A; cyc("R4 open A");
        ask(ADR_B, "R4 same bucket");
        ask(32'h0000_0007, "R4 other bucket");
        wr(3, 7, "R7 clear all");

        // R3: rate window with tick
        wr(1, 2, "R8 write rate");
        win_tick = 1; cyc("R3 tick");
        open_evt = 1; open_addr = 32'h0000_0008; cyc("R3 open");
        open_evt = 1; open_addr = 32'h0000_0009; cyc("R3 open");
        ask(32'h0000_0007, "R3 rate full");
        win_tick = 1; cyc("R3 tick");
        ask(32'h0000_0007, "R3 new window");
        win_tick = 1; open_evt = 1; open_addr = 32'h0000_000A; cyc("R3 tick+open");
        ask(32'h0000_0007, "R3 counted in new window");
        open_evt = 1; open_addr = 32'h0000_000B; cyc("R3 open");
        ask(32'h0000_0007, "R3 limit again");

        // R7: set and clear in the same cycle, set wins
        try_valid = 1; try_addr = 32'h0000_0007; cfg_we = 1; cfg_sel = 2'd3; cfg_wdata = 7;
        cyc("R7 set wins");
        cyc("R7 after collision");
        wr(3, 7, "R7 clear");
        cyc("R7 cleared");

        // R8: zero limit denies
        wr(1, 1000, "R8 write rate");
        win_tick = 1; cyc("R8 tick");
        wr(0, 0, "R8 zero glb");
        ask(32'h0000_0007, "R8 zero limit");
        wr(3, 7, "R7 clear");

        // R10: ceiling saturation
        wr(0, MAXC, "R8 glb max");
        wr(1, MAXC, "R8 rate max");
        wr(2, MAXC, "R8 host max");
        for (int i = 0; i < MAXC + 40; i++) begin
            open_evt = 1; open_addr = ADR_A; cyc("R10 fill");
        end
        ask(ADR_A, "R10 saturated");
        for (int i = 0; i < MAXC + 40; i++) begin
            drop_evt = 1; drop_addr = ADR_A; cyc("R10 drain");
        end
        win_tick = 1; cfg_we = 1; cfg_sel = 2'd3; cfg_wdata = 7; cyc("R10 reset window");
        ask(ADR_A, "R10 recovered");

        // random mix with small limits and colliding addresses
        for (int i = 0; i < 8; i++) pool[i] = $urandom();
        pool[1] = ADR_A; pool[2] = ADR_B;
        wr(0, 6, "R8 glb"); wr(1, 8, "R8 rate"); wr(2, 3, "R8 host");
        for (int i = 0; i < 4000; i++) begin
            open_evt  = ($urandom_range(0, 99) < 40);
            open_addr = pool[$urandom_range(0, 7)];
            estab_evt = ($urandom_range(0, 99) < 20);
            estab_addr = pool[$urandom_range(0, 7)];
            drop_evt  = ($urandom_range(0, 99) < 20);
            drop_addr = pool[$urandom_range(0, 7)];
            win_tick  = ($urandom_range(0, 99) < 5);
            try_valid = ($urandom_range(0, 99) < 50);
            try_addr  = pool[$urandom_range(0, 7)];
            if ($urandom_range(0, 99) < 8) begin
                cfg_we = 1;
                cfg_sel = 2'($urandom_range(0, 3));
                cfg_wdata = CNT_W'(cfg_sel == 2'd3 ? $urandom_range(0, 7) : $urandom_range(0, 8));
            end
            cyc("R5 random");
        end

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end
endmodule